// File: doc/BRIEF.md
# Two-Channel Sequential Break Detector

This block sits beside a processor's debug comparators and turns their per-cycle match strobes into a single break request. Two channels, A and B, each deliver one strobe per bus cycle. In independent mode, a match on either channel qualifies. In sequential mode, channel A arms the detector, and a later channel B match fires the break. A same-cycle A+B pair is rejected, except when channel A is configured as a pre-execution break on an instruction-fetch cycle.

An optional count-down register requires several qualifying matches before a break is raised. Matches inside a repeat loop of fewer than three instructions are ignored. The break is then ranked against fetch and operand exceptions raised by the same instruction. The ranking depends on whether the break is a pre-execution or a post-execution break. The winning event is reported as a 2-bit code. Sticky per-channel match flags are kept until a synchronous clear. All outputs are registered and change on the clock edge after the inputs that cause them.

Top module: `seq_break_unit`

## Requirements
- R1: While rst_ni is low, and after its release, the state is as follows until a match: brk_o=0, evt_o=0, flag_a_o=0, flag_b_o=0, armed_o=0, cnt_o=0. Every output reflects the inputs of the previous clock edge.
- R2: With seq_en_i=0, a match on either channel alone qualifies.
- R3: With seq_en_i=1:
  - A channel B match qualifies only when armed_o is 1, meaning channel A matched in an earlier cycle.
  - A channel B match without arming does not qualify.
  - A channel A match sets armed_o.
- R4: With seq_en_i=1 and the detector not armed, a cycle with both matches does not qualify when a_fetch_pre_i=0. It does qualify when a_fetch_pre_i=1, and then both flags become 1.
- R5: armed_o holds until one of two things happens. A qualifying match fires a break in sequential mode, which clears it. Or flag_clr_i is high, which clears it.
- R6: cnt_load_i=1 loads cnt_val_i into cnt_o; the load wins over a decrement. With cnt_en_i=1, a qualifying match when cnt_o>1 decrements cnt_o and fires no break. A qualifying match when cnt_o<=1 fires, and cnt_o is left unchanged. With cnt_en_i=0, every qualifying match fires.
- R7: While short_loop_i=1 no match qualifies: no break fires and cnt_o does not change.
- R8: A fetch exception wins over everything: evt_o=2 and brk_o=0.
- R9: A pre-execution break (brk_pre_i=1) wins over an operand exception: evt_o=1.
- R10: An operand exception wins over a post-execution break (brk_pre_i=0): evt_o=3 and brk_o=0.
- R11: flag_a_o and flag_b_o are set by their channel's match and stay set. flag_clr_i clears both flags and the armed state, and it wins over a match in the same cycle.
- R12: The codes of evt_o are 0 none, 1 break, 2 fetch exception, 3 operand exception. brk_o is 1 exactly when evt_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_en_i | input | 1 | Sequential A-then-B mode |
| a_fetch_pre_i | input | 1 | Channel A is a pre-execution fetch break |
| brk_pre_i | input | 1 | Break kind: 1 pre-execution, 0 post-execution |
| cnt_en_i | input | 1 | Enable execution counting |
| cnt_load_i | input | 1 | Load the count register |
| cnt_val_i | input | CNT_W | Count value to load |
| match_a_i | input | 1 | Channel A match strobe |
| match_b_i | input | 1 | Channel B match strobe |
| short_loop_i | input | 1 | Inside a repeat loop of under three instructions |
| fetch_exc_i | input | 1 | Instruction-fetch exception in this instruction |
| oper_exc_i | input | 1 | Operand exception in this instruction |
| flag_clr_i | input | 1 | Synchronous clear of flags and armed state |
| brk_o | output | 1 | Break request |
| evt_o | output | 2 | Winning event code |
| flag_a_o | output | 1 | Sticky channel A match flag |
| flag_b_o | output | 1 | Sticky channel B match flag |
| armed_o | output | 1 | Channel A has armed the sequence |
| cnt_o | output | CNT_W | Execution count register |

## Verification
Directed sequences in both modes separate the four basic cases:
- B before A
- B on its own
- A then B in a later cycle
- A and B in the same cycle, with the fetch-break setting both on and off

These show whether arming and the single-cycle exception are told apart. Count sequences that start from loads of 3 and 0 distinguish a decrement from a fire at the last step. Pairing each break kind with each exception type pins down the ranking. A long random run mixes these inputs, with clears and short loops arriving at random moments. It compares every output each cycle against a reference model in the bench.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_BRK   = 2'd1,
    EVT_FETCH = 2'd2,
    EVT_OPER  = 2'd3
  } evt_e;
endpackage

// File: rtl/sbd_seq_cond.sv
module sbd_seq_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seq_en_i,
  input  logic a_fetch_pre_i,
  input  logic match_a_i,
  input  logic match_b_i,
  input  logic short_loop_i,
  input  logic clr_i,
  input  logic fire_i,
  output logic qual_o,
  output logic armed_o
);
  logic armed_q, armed_d;
  logic cond_seq, cond_ind;

  // B must follow an earlier A, unless A is a pre-exec fetch break
  assign cond_seq = match_b_i & (armed_q | (match_a_i & a_fetch_pre_i));
  assign cond_ind = match_a_i | match_b_i;
  assign qual_o   = ~short_loop_i & (seq_en_i ? cond_seq : cond_ind);

  always_comb begin
    armed_d = armed_q;
    if (clr_i)                   armed_d = 1'b0;
    else if (seq_en_i && fire_i) armed_d = 1'b0;
    else if (match_a_i)          armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  a_r3_b_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_en_i && match_b_i && !match_a_i && !armed_q) |-> !qual_o);

  a_r5_arm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && !fire_i) |=> armed_q);
endmodule

// File: rtl/sbd_exec_cnt.sv
module sbd_exec_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             qual_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic last;
  logic dec;

  assign last   = (cnt_q <= ONE);
  assign dec    = qual_i & cnt_en_i & ~last;
  assign fire_o = qual_i & (~cnt_en_i | last);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)   cnt_d = val_i;
    else if (dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r6_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && qual_i && !load_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

  a_r6_no_fire_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && cnt_q > ONE) |-> !fire_o);
endmodule

// File: rtl/sbd_prio.sv
module sbd_prio
  import sbd_pkg::*;
(
  input  logic fetch_exc_i,
  input  logic oper_exc_i,
  input  logic fire_i,
  input  logic brk_pre_i,
  output evt_e evt_o
);
  always_comb begin
    if (fetch_exc_i)            evt_o = EVT_FETCH;
    else if (fire_i && brk_pre_i) evt_o = EVT_BRK;
    else if (oper_exc_i)        evt_o = EVT_OPER;
    else if (fire_i)            evt_o = EVT_BRK;
    else                        evt_o = EVT_NONE;
  end
endmodule

// File: rtl/seq_break_unit.sv
module seq_break_unit
  import sbd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_en_i,
  input  logic             a_fetch_pre_i,
  input  logic             brk_pre_i,
  input  logic             cnt_en_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             match_a_i,
  input  logic             match_b_i,
  input  logic             short_loop_i,
  input  logic             fetch_exc_i,
  input  logic             oper_exc_i,
  input  logic             flag_clr_i,
  output logic             brk_o,
  output logic [1:0]       evt_o,
  output logic             flag_a_o,
  output logic             flag_b_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic qual, fire;
  evt_e evt_d, evt_q;
  logic [NUM_CH-1:0] match, flag_q;

  assign match[CH_A] = match_a_i;
  assign match[CH_B] = match_b_i;

  sbd_seq_cond u_cond (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .seq_en_i      (seq_en_i),
    .a_fetch_pre_i (a_fetch_pre_i),
    .match_a_i     (match_a_i),
    .match_b_i     (match_b_i),
    .short_loop_i  (short_loop_i),
    .clr_i         (flag_clr_i),
    .fire_i        (fire),
    .qual_o        (qual),
    .armed_o       (armed_o)
  );

  sbd_exec_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en_i),
    .load_i   (cnt_load_i),
    .val_i    (cnt_val_i),
    .qual_i   (qual),
    .fire_o   (fire),
    .cnt_o    (cnt_o)
  );

  sbd_prio u_prio (
    .fetch_exc_i (fetch_exc_i),
    .oper_exc_i  (oper_exc_i),
    .fire_i      (fire),
    .brk_pre_i   (brk_pre_i),
    .evt_o       (evt_d)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[c] <= 1'b0;
      else if (flag_clr_i) flag_q[c] <= 1'b0;
      else if (match[c])   flag_q[c] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= EVT_NONE;
      brk_o <= 1'b0;
    end else begin
      evt_q <= evt_d;
      brk_o <= (evt_d == EVT_BRK);
    end
  end

  assign evt_o    = evt_q;
  assign flag_a_o = flag_q[CH_A];
  assign flag_b_o = flag_q[CH_B];

  a_r4_same_cycle_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_en_i && match_a_i && match_b_i && !armed_o && !a_fetch_pre_i) |=> !brk_o);

  a_r7_short_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_loop_i && !cnt_load_i) |=> ($stable(cnt_o) && !brk_o));

  a_r8_fetch_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_exc_i |=> (evt_o == EVT_FETCH && !brk_o));

  a_r10_oper_over_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper_exc_i && !fetch_exc_i && !brk_pre_i) |=> (evt_o == EVT_OPER));

  a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_a_o && !flag_clr_i) |=> flag_a_o);

  a_r12_brk_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (evt_o == EVT_BRK));
endmodule

// File: tb/tb_seq_break_unit.sv
`timescale 1ns/1ps
module tb_seq_break_unit;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic seq_en, apf, pre, ce, ld, ma, mb, sl, fe, oe, clr;
  logic [CNT_W-1:0] val;
  logic brk;
  logic [1:0] evt;
  logic fa, fb, arm;
  logic [CNT_W-1:0] cnt;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic m_fa, m_fb, m_arm, m_brk;
  logic [1:0] m_evt;
  logic [CNT_W-1:0] m_cnt;

  always #2.5 clk = ~clk;

  seq_break_unit #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .seq_en_i(seq_en), .a_fetch_pre_i(apf),
    .brk_pre_i(pre), .cnt_en_i(ce), .cnt_load_i(ld), .cnt_val_i(val),
    .match_a_i(ma), .match_b_i(mb), .short_loop_i(sl), .fetch_exc_i(fe),
    .oper_exc_i(oe), .flag_clr_i(clr), .brk_o(brk), .evt_o(evt),
    .flag_a_o(fa), .flag_b_o(fb), .armed_o(arm), .cnt_o(cnt)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_evt(input logic f_exc, input logic o_exc,
                                         input logic fire, input logic brk_pre);
    if (f_exc)              return 2'd2;
    if (fire && brk_pre)    return 2'd1;
    if (o_exc)              return 2'd3;
    if (fire)               return 2'd1;
    return 2'd0;
  endfunction

  task automatic idle_inputs();
    ma = 0; mb = 0; ld = 0; sl = 0; fe = 0; oe = 0; clr = 0; val = '0;
  endtask

  task automatic compare_all(input string tag);
    check(tag, "brk_o", brk, m_brk);
    check(tag, "evt_o", evt, m_evt);
    check(tag, "flag_a_o", fa, m_fa);
    check(tag, "flag_b_o", fb, m_fb);
    check(tag, "armed_o", arm, m_arm);
    check(tag, "cnt_o", cnt, m_cnt);
  endtask

  // one clock with the current inputs; model computed from pre-edge state
  task automatic step(input string tag);
    logic cond, qual, last, fire;
    logic [CNT_W-1:0] cnt_n;
    logic arm_n;
    cond = seq_en ? (mb & (m_arm | (ma & apf))) : (ma | mb);
    qual = cond & ~sl;
    last = (m_cnt <= 1);
    fire = qual & (~ce | last);
    cnt_n = ld ? val : ((qual & ce & ~last) ? m_cnt - 1'b1 : m_cnt);
    arm_n = clr ? 1'b0 : ((seq_en & fire) ? 1'b0 : (ma ? 1'b1 : m_arm));
    @(posedge clk); #1;
    m_evt = ref_evt(fe, oe, fire, pre);
    m_brk = (m_evt == 2'd1);
    m_fa  = clr ? 1'b0 : (m_fa | ma);
    m_fb  = clr ? 1'b0 : (m_fb | mb);
    m_arm = arm_n;
    m_cnt = cnt_n;
    compare_all(tag);
    idle_inputs();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    seq_en = 0; apf = 0; pre = 0; ce = 0;
    idle_inputs();
    m_fa = 0; m_fb = 0; m_arm = 0; m_brk = 0; m_evt = 0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    rst_ni = 1'b1;
    step("R1");

    // R2: independent mode, B alone fires
    mb = 1; step("R2");
    check("R2", "brk_o lit", brk, 1);
    ma = 1; step("R2");
    check("R2", "evt_o lit", evt, 1);

    // R3: sequential, B alone then A then later B
    clr = 1; step("R11");
    seq_en = 1;
    mb = 1; step("R3");
    check("R3", "brk_o B alone", brk, 0);
    ma = 1; step("R3");
    check("R3", "armed_o after A", arm, 1);
    step("R5");
    step("R5");
    check("R5", "armed_o held", arm, 1);
    mb = 1; step("R3");
    check("R3", "brk_o A then B", brk, 1);
    check("R5", "armed_o consumed", arm, 0);

    // R4: same-cycle A+B
    clr = 1; step("R11");
    apf = 0; ma = 1; mb = 1; step("R4");
    check("R4", "brk_o same cycle", brk, 0);
    clr = 1; step("R11");
    apf = 1; ma = 1; mb = 1; step("R4");
    check("R4", "brk_o fetch-pre", brk, 1);
    check("R4", "flags", {fa, fb}, 3);
    apf = 0;

    // R5: clear disarms
    ma = 1; step("R5");
    clr = 1; step("R5");
    check("R5", "armed_o cleared", arm, 0);
    mb = 1; step("R5");
    check("R5", "brk_o after clear", brk, 0);

    // R6: counting
    seq_en = 0; ce = 1;
    ld = 1; val = 8'd3; step("R6");
    check("R6", "cnt_o load", cnt, 3);
    ma = 1; step("R6");
    check("R6", "cnt_o dec", cnt, 2);
    check("R6", "brk_o early", brk, 0);
    ma = 1; step("R6");
    ma = 1; step("R6");
    check("R6", "brk_o at one", brk, 1);
    check("R6", "cnt_o held", cnt, 1);
    ld = 1; val = 8'd0; step("R6");
    mb = 1; step("R6");
    check("R6", "brk_o at zero", brk, 1);

    // R7: short loop
    ld = 1; val = 8'd5; step("R7");
    ma = 1; sl = 1; step("R7");
    check("R7", "cnt_o", cnt, 5);
    check("R7", "brk_o", brk, 0);
    ce = 0;

    // R8..R10 ranking
    pre = 1; ma = 1; fe = 1; oe = 1; step("R8");
    check("R8", "evt_o", evt, 2);
    pre = 1; ma = 1; oe = 1; step("R9");
    check("R9", "evt_o", evt, 1);
    pre = 0; ma = 1; oe = 1; step("R10");
    check("R10", "evt_o", evt, 3);
    check("R10", "brk_o", brk, 0);

    // R11: clear wins over same-cycle match
    ma = 1; mb = 1; clr = 1; step("R11");
    check("R11", "flags", {fa, fb}, 0);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int blk = 0; blk < 20; blk++) begin
      seq_en = $urandom_range(0, 1);
      ce     = $urandom_range(0, 1);
      apf    = $urandom_range(0, 1);
      for (int i = 0; i < 200; i++) begin
        ma  = ($urandom_range(0, 3) == 0);
        mb  = ($urandom_range(0, 3) == 0);
        clr = ($urandom_range(0, 19) == 0);
        ld  = ($urandom_range(0, 19) == 0);
        val = CNT_W'($urandom_range(0, 5));
        sl  = ($urandom_range(0, 9) == 0);
        fe  = ($urandom_range(0, 9) == 0);
        oe  = ($urandom_range(0, 9) == 0);
        pre = $urandom_range(0, 1);
        step("R12");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule